// File: doc/BRIEF.md
# Multi-Channel A/D Scan Sequencer

This block sits between a control register and a single-channel analog-to-digital conversion engine. Software programs the scan through one control word: a run bit, a mode bit that selects scanning, a channel span field, an interrupt enable and a completion flag. Once the run bit is set, the sequencer launches conversions one at a time in ascending channel order. It waits for each result and stores it in the result register owned by that channel. When the last channel is finished, it sets the completion flag and clears the run bit itself.

In scan mode the span field gives the highest channel converted, and the scan always begins at channel 0. With the mode bit clear, only the one channel named by the span field is converted. The interrupt request is a level: it is high while the completion flag and the interrupt enable are both set. If software clears the run bit during a scan, the scan stops after the conversion that is in flight. That result is discarded and the completion flag is not raised.

The sequencer is a four-state machine: IDLE, LAUNCH, WAIT and FINISH. IDLE moves to LAUNCH when the run bit is 1. On that transition it latches the first and last channel of the scan. LAUNCH always moves to WAIT and issues the start pulse. WAIT stays put until the converter signals done, then takes one of three exits: back to IDLE on abort if the run bit is 0, to FINISH if the last channel is done, and to LAUNCH otherwise, with the channel index advanced. FINISH always returns to IDLE, and in that cycle it sets the flag and clears the run bit.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the run bit, completion flag, interrupt request, start pulse and every result register are 0.
- R2: Control word layout (default parameters): bit 0 run, bit 1 scan mode, bits 3:2 span, bit 4 interrupt enable, bit 5 completion flag. The word is written when `ctl_we` is high at a clock edge. If the write sets the run bit, `conv_start` is high during the second cycle after the write cycle.
- R3: In scan mode, channels 0 up to the span value are converted in ascending order. `conv_start` lasts exactly one cycle. A new start is issued only after the previous `conv_done` has arrived.
- R4: With scan mode clear, exactly one conversion is issued, on the channel given by the span field.
- R5: The data that comes with `conv_done` is stored in the result register of the channel being converted (channel k occupies `res_flat[k*10 +: 10]`). It is visible in the cycle after the done pulse. Result registers change only on a done pulse, so registers of unselected channels keep their values.
- R6: One cycle after the last result is stored, the completion flag reads 1 and the run bit reads 0.
- R7: The completion flag is sticky. Starting a new scan does not clear it, and writing 1 to its bit has no effect. Only a write of 0 to its bit clears it.
- R8: `irq_req` equals the completion flag ANDed with the interrupt enable. It falls as soon as either of the two is cleared.
- R9: If software writes 0 to the run bit during a scan, the sequencer issues no further starts. It discards the result of the conversion in flight and leaves the completion flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word written on `ctl_we` |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_ch | output | 2 | Channel index for the conversion |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 10 | Conversion result, valid with `conv_done` |
| stat_go | output | 1 | Current run bit |
| stat_done | output | 1 | Completion flag |
| irq_req | output | 1 | Interrupt request level |
| res_flat | output | 40 | Result registers, channel k at bits k*10 +: 10 |

## Verification
Each result has a fixed due time. A control write captured at one edge starts the scan with `conv_start` in the second cycle after it. A stored result appears one edge after the done pulse, and the completion flag and cleared run bit follow one edge later. The interrupt level follows a control write at the very next edge. The bench drives every input on falling edges, finds the rising edge at which a done pulse is sampled, and then reads the outputs on the following falling edges, exactly at those offsets. The model converter answers after a fixed latency and keeps a log of the channels it was told to start, so the bench can check order, count and overlap without looking inside the design.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } scan_state_t;

    // control word bit positions below the span field
    localparam int unsigned POS_GO    = 0;
    localparam int unsigned POS_MULTI = 1;
    localparam int unsigned POS_SPAN  = 2;

endpackage

// File: rtl/adc_scan_ctl.sv
module adc_scan_ctl #(
    parameter int unsigned CH_W = 2,
    localparam int unsigned WD_W = 4 + CH_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic [WD_W-1:0] ctl_wdata,
    input  logic            finish,
    output logic            go_q,
    output logic            multi_q,
    output logic [CH_W-1:0] span_q,
    output logic            ien_q,
    output logic            done_q
);
    import adc_scan_pkg::*;

    localparam int unsigned POS_IEN  = POS_SPAN + CH_W;
    localparam int unsigned POS_DONE = POS_IEN + 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q    <= 1'b0;
            multi_q <= 1'b0;
            span_q  <= '0;
            ien_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (ctl_we) begin
                go_q    <= ctl_wdata[POS_GO];
                multi_q <= ctl_wdata[POS_MULTI];
                span_q  <= ctl_wdata[POS_SPAN +: CH_W];
                ien_q   <= ctl_wdata[POS_IEN];
                if (!ctl_wdata[POS_DONE]) begin
                    done_q <= 1'b0;
                end
            end
            // hardware completion wins over a same-cycle software write
            if (finish) begin
                go_q   <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm #(
    parameter int unsigned CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            multi,
    input  logic [CH_W-1:0] span,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_ch,
    output logic            store_en,
    output logic            finish
);
    import adc_scan_pkg::*;

    scan_state_t     state_q, state_d;
    logic [CH_W-1:0] cur_q, cur_d;
    logic [CH_W-1:0] last_q, last_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            last_q  <= last_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        last_d  = last_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d = ST_LAUNCH;
                    cur_d   = multi ? '0 : span;
                    last_d  = span;
                end
            end
            ST_LAUNCH: begin
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_done) begin
                    if (!go) begin
                        state_d = ST_IDLE;
                    end else if (cur_q == last_q) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_LAUNCH;
                        cur_d   = cur_q + 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        conv_start = 1'b0;
        store_en   = 1'b0;
        finish     = 1'b0;
        conv_ch    = cur_q;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LAUNCH: conv_start = 1'b1;
            ST_WAIT:   store_en   = conv_done & go;
            ST_FINISH: finish     = 1'b1;
        endcase
    end

endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 10,
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     store_en,
    input  logic [CH_W-1:0]          store_ch,
    input  logic [DATA_W-1:0]        store_data,
    output logic [NUM_CH*DATA_W-1:0] res_flat
);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_slot
        logic [DATA_W-1:0] slot_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (store_en && (store_ch == CH_W'(gi))) begin
                slot_q <= store_data;
            end
        end

        assign res_flat[gi*DATA_W +: DATA_W] = slot_q;
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 10,
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned WD_W = 4 + CH_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_we,
    input  logic [WD_W-1:0]          ctl_wdata,
    output logic                     conv_start,
    output logic [CH_W-1:0]          conv_ch,
    input  logic                     conv_done,
    input  logic [DATA_W-1:0]        conv_data,
    output logic                     stat_go,
    output logic                     stat_done,
    output logic                     irq_req,
    output logic [NUM_CH*DATA_W-1:0] res_flat
);

    logic            go_q, multi_q, ien_q, done_q;
    logic [CH_W-1:0] span_q;
    logic            store_en, finish;

    adc_scan_ctl #(.CH_W(CH_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .finish    (finish),
        .go_q      (go_q),
        .multi_q   (multi_q),
        .span_q    (span_q),
        .ien_q     (ien_q),
        .done_q    (done_q)
    );

    adc_scan_fsm #(.CH_W(CH_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go_q),
        .multi      (multi_q),
        .span       (span_q),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_ch    (conv_ch),
        .store_en   (store_en),
        .finish     (finish)
    );

    adc_scan_results #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_en   (store_en),
        .store_ch   (conv_ch),
        .store_data (conv_data),
        .res_flat   (res_flat)
    );

    assign stat_go   = go_q;
    assign stat_done = done_q;
    assign irq_req   = done_q & ien_q;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 10,
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ctl_we,
    input logic                     conv_start,
    input logic [CH_W-1:0]          conv_ch,
    input logic                     conv_done,
    input logic                     stat_go,
    input logic                     stat_done,
    input logic                     irq_req,
    input logic [NUM_CH*DATA_W-1:0] res_flat
);

    logic            pending_q;
    logic            in_scan_q;
    logic [CH_W-1:0] prev_ch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            in_scan_q <= 1'b0;
            prev_ch_q <= '0;
        end else begin
            if (conv_start)      pending_q <= 1'b1;
            else if (conv_done)  pending_q <= 1'b0;
            if (!stat_go) begin
                in_scan_q <= 1'b0;
            end else if (conv_start) begin
                in_scan_q <= 1'b1;
                prev_ch_q <= conv_ch;
            end
        end
    end

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !pending_q);

    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && in_scan_q) |-> (conv_ch == CH_W'(prev_ch_q + 1'b1)));

    assert_results_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(res_flat));

    assert_done_clears_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_done) |-> !stat_go);

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_done && !ctl_we) |=> stat_done);

    assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_done |-> !irq_req);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .conv_done  (conv_done),
    .stat_go    (stat_go),
    .stat_done  (stat_done),
    .irq_req    (irq_req),
    .res_flat   (res_flat)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;

    localparam int LAT = 3;
    localparam int NV  = 6;
    // each entry: {scan mode, span[1:0], irq enable}
    localparam logic [3:0] VEC [NV] = '{4'b1_10_1, 4'b1_11_0, 4'b1_00_1,
                                        4'b0_10_0, 4'b0_01_1, 4'b1_01_1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [5:0]  ctl_wdata = '0;
    logic        conv_start;
    logic [1:0]  conv_ch;
    logic        cv_done = 1'b0;
    logic [9:0]  cv_data = '0;
    logic        stat_go, stat_done, irq_req;
    logic [39:0] res_flat;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(cv_done),
        .conv_data(cv_data), .stat_go(stat_go), .stat_done(stat_done),
        .irq_req(irq_req), .res_flat(res_flat)
    );

    // converter model
    int         scan_tag = 0;
    int         nstarts = 0;
    int         overlap = 0;
    int         cv_cnt = 0;
    bit         cv_busy = 0;
    logic [1:0] cv_ch = '0;
    logic [1:0] start_log [16];

    always @(negedge clk) begin
        cv_done = 1'b0;
        if (cv_busy) begin
            cv_cnt--;
            if (cv_cnt == 0) begin
                cv_done = 1'b1;
                cv_data = {scan_tag[6:0], cv_ch, 1'b1};
                cv_busy = 0;
            end
        end
        if (rst_n && conv_start) begin
            if (cv_busy) overlap++;
            cv_busy = 1;
            cv_cnt  = LAT;
            cv_ch   = conv_ch;
            if (nstarts < 16) start_log[nstarts] = conv_ch;
            nstarts++;
        end
    end

    function automatic logic [5:0] mk(bit go, bit multi, logic [1:0] span, bit ien, bit dn);
        return {dn, ien, span, multi, go};
    endfunction

    function automatic logic [9:0] slot(int k);
        return res_flat[k*10 +: 10];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] w);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (stat_go && t < 500) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    logic [9:0] exp_res [4];

    initial begin
        for (int k = 0; k < 4; k++) exp_res[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!stat_go, "R1 go", stat_go, 0);
        chk(!stat_done, "R1 done", stat_done, 0);
        chk(!irq_req, "R1 irq", irq_req, 0);
        chk(!conv_start, "R1 start", conv_start, 0);
        chk(res_flat == '0, "R1 results", int'(res_flat[31:0]), 0);

        // R2 start latency, R6 completion timing (single channel 0 scan)
        scan_tag = 100;
        nstarts = 0;
        wr(mk(1, 1, 2'd0, 0, 1));
        chk(!conv_start && stat_go, "R2 no start yet", conv_start, 0);
        @(negedge clk);
        chk(conv_start && conv_ch == 2'd0, "R2 start due", conv_start, 1);
        do @(posedge clk); while (!cv_done);
        @(negedge clk);
        exp_res[0] = {7'd100, 2'd0, 1'b1};
        chk(slot(0) == exp_res[0], "R5 stored next cycle", slot(0), exp_res[0]);
        chk(!stat_done && stat_go, "R6 flag not yet", stat_done, 0);
        @(negedge clk);
        chk(stat_done && !stat_go, "R6 flag and go", {stat_done, stat_go}, 2);
        chk(!irq_req, "R8 irq off when disabled", irq_req, 0);

        // table of scans: R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            bit         m  = VEC[v][3];
            logic [1:0] sp = VEC[v][2:1];
            bit         ie = VEC[v][0];
            int first = m ? 0 : int'(sp);
            int last  = int'(sp);
            wr(mk(0, 0, 2'd0, 0, 0));
            scan_tag = v + 1;
            nstarts = 0;
            wr(mk(1, m, sp, ie, 1));
            wait_idle();
            @(negedge clk);
            chk(nstarts == last - first + 1, m ? "R3 start count" : "R4 start count",
                nstarts, last - first + 1);
            for (int k = 0; k < nstarts && k < 16; k++)
                chk(int'(start_log[k]) == first + k, m ? "R3 order" : "R4 channel",
                    start_log[k], first + k);
            for (int k = first; k <= last; k++) exp_res[k] = {scan_tag[6:0], 2'(k), 1'b1};
            for (int k = 0; k < 4; k++)
                chk(slot(k) == exp_res[k], "R5 result", slot(k), exp_res[k]);
            chk(stat_done && !stat_go, "R6 end state", {stat_done, stat_go}, 2);
            chk(irq_req == ie, "R8 irq level", irq_req, ie);
        end
        chk(overlap == 0, "R3 overlap", overlap, 0);

        // R7 sticky flag, R8 irq tracking
        scan_tag = 50;
        wr(mk(1, 1, 2'd1, 1, 1));
        chk(stat_done, "R7 start keeps flag", stat_done, 1);
        wait_idle();
        wr(mk(0, 0, 2'd0, 1, 1));
        chk(stat_done && irq_req, "R7 write 1 no effect", stat_done, 1);
        wr(mk(0, 0, 2'd0, 0, 1));
        chk(!irq_req && stat_done, "R8 irq drops with enable", irq_req, 0);
        wr(mk(0, 0, 2'd0, 1, 1));
        chk(irq_req, "R8 irq returns", irq_req, 1);
        wr(mk(0, 0, 2'd0, 1, 0));
        chk(!stat_done, "R7 write 0 clears", stat_done, 0);
        chk(!irq_req, "R8 irq drops with flag", irq_req, 0);
        exp_res[0] = {7'd50, 2'd0, 1'b1};
        exp_res[1] = {7'd50, 2'd1, 1'b1};

        // R9 abort during second conversion
        scan_tag = 77;
        nstarts = 0;
        wr(mk(1, 1, 2'd3, 1, 1));
        while (nstarts < 2) @(posedge clk);
        wr(mk(0, 1, 2'd3, 1, 1));
        repeat (30) @(negedge clk);
        exp_res[0] = {7'd77, 2'd0, 1'b1};
        chk(nstarts == 2, "R9 no further starts", nstarts, 2);
        chk(!stat_done, "R9 flag stays clear", stat_done, 0);
        chk(!stat_go, "R9 run bit", stat_go, 0);
        chk(slot(0) == exp_res[0], "R9 earlier result kept", slot(0), exp_res[0]);
        chk(slot(1) == exp_res[1], "R9 in-flight result dropped", slot(1), exp_res[1]);
        chk(overlap == 0, "R3 overlap final", overlap, 0);

        finish_run();
    end

endmodule